// File: doc/BRIEF.md
# Interrupt Priority Acceptance Controller

This block decides, cycle by cycle, which pending maskable interrupt the processor takes. It keeps a request bit and a three-bit priority level for each of `N_SRC` sources. It also keeps a processor priority threshold and a global enable flag. A source qualifies when the enable flag is set, its request bit is set, and its level is strictly above the threshold. Among the qualifying sources, the one with the highest level wins. The winner is reported as a registered one-cycle pulse with its index, and its request bit is cleared at the same moment.

Writes to the threshold and to the source levels do not act at once. A threshold write tagged as a return-class update is held back two cycles, and one tagged as a load-class update three cycles. A source level write is held back two cycles. Until a held value takes effect, decisions use the older effective value. A newer write replaces one that is still waiting.

Top module: `irq_accept_ctrl`

## Requirements
- R1: An accept occurs only when the enable flag is 1, the source's request bit is 1, and its effective level is strictly greater than the effective threshold. `flag_we` loads `flag_din` into the enable flag, and the flag's new value is used from the next cycle.
- R2: A source whose effective level code is 0 is never accepted. Codes 1 to 7 mean levels 1 to 7, and 7 is the highest.
- R3: A threshold of n admits only levels n+1 and above, so a threshold of 7 blocks every source.
- R4: A threshold write sampled at clock edge k with `thr_kind`=0 (return-class) is used by decisions from the cycle after edge k+2.
- R5: A threshold write sampled at edge k with `thr_kind`=1 (load-class) is used by decisions from the cycle after edge k+3.
- R6: A level write for source i (`lvl_we[i]`=1, value `lvl_din`) sampled at edge k is used from the cycle after edge k+2. Before that, the previous effective level applies.
- R7: A write that arrives while an older write to the same register is still waiting replaces the waiting value and restarts the delay. An older write whose delay expires on the same edge still takes effect first.
- R8: Among the qualifying sources, the highest level wins, and equal levels go to the lowest index.
- R9: A decision made in the cycle before edge e appears as `acc_pulse`=1 with `acc_idx` after edge e, and the winner's request bit clears at edge e. `acc_idx` reads 0 when there is no pulse. A `req_set` bit asserted on edge e sets the request bit and overrides that clear.
- R10: After reset, all levels, the threshold, the enable flag, every request bit and the outputs are 0, and no write is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Write strobe for the global enable flag |
| flag_din | input | 1 | New enable flag value |
| req_set | input | N_SRC | Sets request bits, one per source |
| thr_we | input | 1 | Threshold write strobe |
| thr_kind | input | 1 | 0 = return-class (2-cycle delay), 1 = load-class (3-cycle delay) |
| thr_din | input | LVL_W | New threshold value |
| lvl_we | input | N_SRC | Level write strobe, one per source |
| lvl_din | input | LVL_W | New level value shared by all strobes |
| acc_pulse | output | 1 | One-cycle accept strobe |
| acc_idx | output | IDX_W | Index of the accepted source |
| req_pend | output | N_SRC | Current request bits |

## Verification
The hardest case to reach is a write that overtakes an older write to the same register while the older one is still waiting. This is hardest when a two-cycle write follows a three-cycle one, or when the older delay expires on the same edge as the new write. The directed part issues back-to-back threshold writes of both kinds one cycle apart. It re-raises requests every cycle so that each cycle's effective threshold shows up in the accept stream. The random part writes the threshold and levels at a high rate, so these overlaps also occur many times with varied spacing.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
   typedef enum logic {
      UPD_RETURN = 1'b0,
      UPD_LOAD   = 1'b1
   } upd_kind_e;

   localparam int RETURN_DELAY = 2;
   localparam int LOAD_DELAY   = 3;
   localparam int LEVEL_DELAY  = 2;
   localparam int MAX_DELAY    = 3;
   localparam int DLY_CNT_W    = $clog2(MAX_DELAY + 1);
endpackage

// File: rtl/irq_delayed_reg.sv
module irq_delayed_reg #(
   parameter int WIDTH = 3,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_val,
   input  logic [CNT_W-1:0] wr_dly,
   output logic [WIDTH-1:0] eff_val
);
   generate
      if (WIDTH < 1) begin : g_bad_w
         $error("irq_delayed_reg: WIDTH must be positive");
      end
      if (CNT_W < 1) begin : g_bad_c
         $error("irq_delayed_reg: CNT_W must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] pend_q;
   logic [WIDTH-1:0] eff_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         eff_q  <= '0;
         cnt_q  <= '0;
      end else begin
         if (cnt_q == CNT_W'(1)) eff_q <= pend_q;
         if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
         if (wr_en) begin
            pend_q <= wr_val;
            cnt_q  <= wr_dly;
         end
      end
   end

   assign eff_val = eff_q;

   // R6: value stays put while a write is still counting down
   p_hold_while_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > CNT_W'(1)) |=> $stable(eff_q));

   // R4: the waiting value lands on the final count
   p_commit_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(1)) |=> (eff_q == $past(pend_q)));

   // R7: a write always restarts with a nonzero delay
   p_delay_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_dly != '0));
endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel #(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   parameter int IDX_W = 3
) (
   input  logic                   gate_en,
   input  logic [N_SRC-1:0]       req,
   input  logic [N_SRC*LVL_W-1:0] lvl_flat,
   input  logic [LVL_W-1:0]       thr,
   output logic                   hit,
   output logic [IDX_W-1:0]       hit_idx,
   output logic [N_SRC-1:0]       hit_onehot
);
   logic [N_SRC-1:0] qual;

   genvar gi;
   generate
      for (gi = 0; gi < N_SRC; gi++) begin : g_qual
         assign qual[gi] = gate_en & req[gi] & (lvl_flat[gi*LVL_W +: LVL_W] > thr);
      end
   endgenerate

   logic [LVL_W-1:0] best_lvl;

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      best_lvl = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (qual[i] && (!hit || (lvl_flat[i*LVL_W +: LVL_W] > best_lvl))) begin
            hit      = 1'b1;
            hit_idx  = IDX_W'(i);
            best_lvl = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
   end

   always_comb begin
      hit_onehot = '0;
      if (hit) hit_onehot[hit_idx] = 1'b1;
   end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irq_acc_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag_we,
   input  logic             flag_din,
   input  logic [N_SRC-1:0] req_set,
   input  logic             thr_we,
   input  logic             thr_kind,
   input  logic [LVL_W-1:0] thr_din,
   input  logic [N_SRC-1:0] lvl_we,
   input  logic [LVL_W-1:0] lvl_din,
   output logic             acc_pulse,
   output logic [IDX_W-1:0] acc_idx,
   output logic [N_SRC-1:0] req_pend
);
   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("irq_accept_ctrl: N_SRC must be at least 2");
      end
      if (LVL_W < 1) begin : g_bad_l
         $error("irq_accept_ctrl: LVL_W must be positive");
      end
      if ((1 << IDX_W) < N_SRC) begin : g_bad_i
         $error("irq_accept_ctrl: IDX_W too narrow");
      end
   endgenerate

   localparam logic [DLY_CNT_W-1:0] THR_DLY_RET  = DLY_CNT_W'(RETURN_DELAY);
   localparam logic [DLY_CNT_W-1:0] THR_DLY_LOAD = DLY_CNT_W'(LOAD_DELAY);
   localparam logic [DLY_CNT_W-1:0] LVL_DLY      = DLY_CNT_W'(LEVEL_DELAY);

   logic                   flag_q;
   logic [N_SRC-1:0]       req_q;
   logic                   acc_q;
   logic [IDX_W-1:0]       idx_q;
   logic [LVL_W-1:0]       thr_eff;
   logic [N_SRC*LVL_W-1:0] lvl_flat;
   logic [DLY_CNT_W-1:0]   thr_dly;
   logic                   win_hit;
   logic [IDX_W-1:0]       win_idx;
   logic [N_SRC-1:0]       win_oh;

   upd_kind_e kind_e;
   assign kind_e  = upd_kind_e'(thr_kind);
   assign thr_dly = (kind_e == UPD_LOAD) ? THR_DLY_LOAD : THR_DLY_RET;

   irq_delayed_reg #(.WIDTH(LVL_W), .CNT_W(DLY_CNT_W)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (thr_we),
      .wr_val  (thr_din),
      .wr_dly  (thr_dly),
      .eff_val (thr_eff)
   );

   genvar gs;
   generate
      for (gs = 0; gs < N_SRC; gs++) begin : g_src
         irq_delayed_reg #(.WIDTH(LVL_W), .CNT_W(DLY_CNT_W)) u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lvl_we[gs]),
            .wr_val  (lvl_din),
            .wr_dly  (LVL_DLY),
            .eff_val (lvl_flat[gs*LVL_W +: LVL_W])
         );
      end
   endgenerate

   irq_winner_sel #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
      .gate_en    (flag_q),
      .req        (req_q),
      .lvl_flat   (lvl_flat),
      .thr        (thr_eff),
      .hit        (win_hit),
      .hit_idx    (win_idx),
      .hit_onehot (win_oh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         req_q  <= '0;
         acc_q  <= 1'b0;
         idx_q  <= '0;
      end else begin
         if (flag_we) flag_q <= flag_din;
         req_q <= (req_q & ~win_oh) | req_set;
         acc_q <= win_hit;
         idx_q <= win_hit ? win_idx : '0;
      end
   end

   assign acc_pulse = acc_q;
   assign acc_idx   = idx_q;
   assign req_pend  = req_q;

   // R1: a pulse follows only a cycle with the flag set
   p_accept_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> $past(flag_q));

   // R1: the selector only names a source that is requesting
   p_winner_requested_r1: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> req_q[win_idx]);

   // R2: a level-0 source never wins
   p_level_zero_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> (lvl_flat[win_idx*LVL_W +: LVL_W] != '0));

   // R3: the top threshold blocks every source
   p_top_threshold_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_eff == '1) |=> !acc_q);

   // R9: the index is zero whenever there is no pulse
   p_idle_index_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_q |-> (idx_q == '0));
endmodule

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
   localparam int N = 8;
   localparam int LW = 3;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flag_we = 1'b0, flag_din = 1'b0;
   logic [N-1:0]  req_set = '0;
   logic          thr_we = 1'b0, thr_kind = 1'b0;
   logic [LW-1:0] thr_din = '0;
   logic [N-1:0]  lvl_we = '0;
   logic [LW-1:0] lvl_din = '0;
   logic          acc_pulse;
   logic [IW-1:0] acc_idx;
   logic [N-1:0]  req_pend;

   always #10 clk = ~clk;

   irq_accept_ctrl #(.N_SRC(N), .LVL_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_din(flag_din),
      .req_set(req_set), .thr_we(thr_we), .thr_kind(thr_kind), .thr_din(thr_din),
      .lvl_we(lvl_we), .lvl_din(lvl_din),
      .acc_pulse(acc_pulse), .acc_idx(acc_idx), .req_pend(req_pend));

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference state
   bit          m_flag;
   bit [N-1:0]  m_req;
   bit [LW-1:0] m_thr, m_thr_pend;
   int          m_thr_cnt;
   bit [LW-1:0] m_lvl [N];
   bit [LW-1:0] m_lvl_pend [N];
   int          m_lvl_cnt [N];

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int pick_winner();
      int best = -1;
      int bidx = -1;
      for (int i = 0; i < N; i++)
         if (m_flag && m_req[i] && (m_lvl[i] > m_thr) && (best < 0 || int'(m_lvl[i]) > best)) begin
            best = m_lvl[i];
            bidx = i;
         end
      return bidx;
   endfunction

   task automatic step(string tag);
      int w;
      bit exp_acc;
      int exp_idx;
      w = pick_winner();
      exp_acc = (w >= 0);
      exp_idx = exp_acc ? w : 0;
      if (exp_acc) m_req[w] = 1'b0;
      m_req = m_req | req_set;
      if (flag_we) m_flag = flag_din;
      if (m_thr_cnt == 1) m_thr = m_thr_pend;
      if (m_thr_cnt != 0) m_thr_cnt--;
      if (thr_we) begin
         m_thr_pend = thr_din;
         m_thr_cnt = thr_kind ? 3 : 2;
      end
      for (int i = 0; i < N; i++) begin
         if (m_lvl_cnt[i] == 1) m_lvl[i] = m_lvl_pend[i];
         if (m_lvl_cnt[i] != 0) m_lvl_cnt[i]--;
         if (lvl_we[i]) begin
            m_lvl_pend[i] = lvl_din;
            m_lvl_cnt[i] = 2;
         end
      end
      @(posedge clk);
      #2;
      check(acc_pulse == exp_acc, tag, "acc_pulse", int'(acc_pulse), int'(exp_acc));
      check(int'(acc_idx) == exp_idx, tag, "acc_idx", int'(acc_idx), exp_idx);
      check(req_pend == m_req, tag, "req_pend", int'(req_pend), int'(m_req));
      flag_we = 1'b0;
      req_set = '0;
      thr_we = 1'b0;
      lvl_we = '0;
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic set_lvl(int src, int v, string tag);
      lvl_we = N'(1) << src;
      lvl_din = LW'(v);
      step(tag);
   endtask

   task automatic set_thr(int v, bit kind, string tag);
      thr_we = 1'b1;
      thr_kind = kind;
      thr_din = LW'(v);
      step(tag);
   endtask

   task automatic hammer(int n, bit [N-1:0] mask, string tag);
      for (int i = 0; i < n; i++) begin
         req_set = mask;
         step(tag);
      end
   endtask

   initial begin
      #(20 * 190000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_flag = 0; m_req = '0; m_thr = '0; m_thr_pend = '0; m_thr_cnt = 0;
      for (int i = 0; i < N; i++) begin
         m_lvl[i] = '0; m_lvl_pend[i] = '0; m_lvl_cnt[i] = 0;
      end
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2;
      check(acc_pulse == 1'b0, "R10", "acc_pulse in reset", int'(acc_pulse), 0);
      check(acc_idx == '0, "R10", "acc_idx in reset", int'(acc_idx), 0);
      check(req_pend == '0, "R10", "req_pend in reset", int'(req_pend), 0);
      rst_n = 1'b1;
      run(2, "R10");

      // R1: requests with the flag clear are not taken
      set_lvl(2, 5, "R6");
      run(3, "R6");
      req_set = 8'h04;
      run(3, "R1");
      check(req_pend[2] == 1'b1, "R1", "req held with flag off", int'(req_pend[2]), 1);
      flag_we = 1'b1; flag_din = 1'b1;
      run(3, "R1");

      // R2: level 0 source stays pending
      req_set = 8'h10;
      run(4, "R2");
      check(req_pend[4] == 1'b1, "R2", "level0 req kept", int'(req_pend[4]), 1);

      // R6: level change timing, old level used until effective
      set_lvl(4, 3, "R6");
      run(3, "R6");
      set_lvl(2, 1, "R6");
      hammer(4, 8'h04, "R6");

      // R8: ties to lowest index, higher level first
      set_lvl(1, 4, "R8");
      set_lvl(6, 4, "R8");
      set_lvl(3, 6, "R8");
      run(3, "R8");
      req_set = 8'h4A;
      run(5, "R8");

      // R4/R5: threshold timing by kind
      set_lvl(5, 3, "R4");
      run(3, "R4");
      set_thr(4, 1'b0, "R4");
      hammer(5, 8'h20, "R4");
      set_thr(0, 1'b1, "R5");
      hammer(5, 8'h20, "R5");
      set_thr(2, 1'b1, "R5");
      hammer(5, 8'h20, "R5");

      // R3: top threshold masks all
      for (int i = 0; i < N; i++) set_lvl(i, 7 - (i % 7), "R3");
      set_thr(7, 1'b0, "R3");
      hammer(6, 8'hFF, "R3");
      check(acc_pulse == 1'b0, "R3", "masked at threshold 7", int'(acc_pulse), 0);
      set_thr(5, 1'b1, "R3");
      run(6, "R3");

      // R7: newer writes overtake pending ones
      set_thr(0, 1'b1, "R7");
      set_thr(7, 1'b0, "R7");
      hammer(5, 8'hFF, "R7");
      set_thr(1, 1'b0, "R7");
      run(1, "R7");
      set_thr(6, 1'b1, "R7");
      hammer(6, 8'hFF, "R7");
      set_lvl(0, 7, "R7");
      set_lvl(0, 0, "R7");
      hammer(5, 8'h01, "R7");

      // R9: re-request on the accepting edge wins over the clear
      set_thr(0, 1'b0, "R9");
      run(3, "R9");
      set_lvl(0, 2, "R9");
      run(3, "R9");
      hammer(4, 8'h01, "R9");
      run(3, "R9");

      // random
      for (int k = 0; k < 4000; k++) begin
         req_set = N'($urandom) & N'($urandom);
         if (($urandom % 4) == 0) begin
            thr_we = 1'b1;
            thr_kind = 1'($urandom);
            thr_din = LW'($urandom);
         end
         if (($urandom % 3) == 0) begin
            lvl_we = N'(1) << ($urandom % N);
            lvl_din = LW'($urandom);
         end
         if (($urandom % 40) == 0) begin
            flag_we = 1'b1;
            flag_din = (($urandom % 4) != 0);
         end
         step("RND");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule